// File: doc/BRIEF.md
# Timed-Write Register Sequencer

This block plays back a stream of delayed register writes. The host pushes bytes into a 512-byte queue. The sequencer reads them three at a time as records, each made of a delay, a register address and a value. It holds the write back for the delay and then drives it onto the control-register write port. The delay is counted in ticks of 1 ms. One tick is 48 pulses of a 48 kHz sample strobe. A record with delay zero is written as soon as its last byte has been taken.

The same write port also carries direct writes from the host, and those writes always win. A run bit starts and pauses playback. A one-cycle clear pulse empties the queue and puts the parser back at the start of a record. When the queue runs dry partway through a record, the parser waits with what it already holds until the missing bytes arrive.

Top module: `tw_seq`

## Requirements
- R1: The queue holds 512 bytes and hands them to the parser in the order they were pushed.
- R2: A record is taken as delay byte first, then address byte, then value byte. The sequencer then performs exactly one write of that value to that address.
- R3: For a delay D greater than zero, the write appears on `reg_we` in the cycle after the D*48-th strobe. Strobes are counted from the cycle after the value byte was taken. A strobe in the cycle the value byte is taken is not counted.
- R4: For a delay of zero, the write appears in the cycle after the value byte is taken. With an otherwise empty queue and `run` high, that is the second cycle after the clock edge that stores the value byte.
- R5: When `host_we` is high, `reg_addr` and `reg_wdata` carry the host's address and value. A sequencer write that is due in that cycle waits and appears in the first cycle in which `host_we` is low.
- R6: When the queue empties partway through a record, the parser keeps the bytes it already has. The record completes correctly once the rest arrives.
- R7: A push into a full queue is discarded and sets `fifo_ovf`. The flag stays high until reset or clear.
- R8: While `run` is low, the parser takes no bytes, the delay count and the strobe prescaler hold their values, and no sequencer write is made.
- R9: A clear pulse empties the queue, returns the parser to the delay byte, resets the prescaler and lowers `fifo_ovf`. A push in the same cycle as the clear is discarded.
- R10: After reset, `reg_we` and `fifo_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enables fetching, counting and writing |
| clear | input | 1 | One-cycle flush of queue and parser |
| smp_stb | input | 1 | 48 kHz sample strobe, one cycle wide |
| fifo_we | input | 1 | Host push into the queue |
| fifo_wdata | input | 8 | Byte pushed |
| host_we | input | 1 | Direct host register write |
| host_addr | input | 8 | Direct write address |
| host_wdata | input | 8 | Direct write value |
| reg_we | output | 1 | Control-register write strobe |
| reg_addr | output | 8 | Control-register address |
| reg_wdata | output | 8 | Control-register value |
| fifo_ovf | output | 1 | Sticky queue-overflow flag |

## Verification
A zero-delay write is due on the port two cycles after the edge that stores its value byte. A delayed write is due one cycle after the edge that carries its last counted strobe. A direct host write shows on the port in the same cycle it is driven, and the overflow flag rises on the edge of the rejected push. The bench drives inputs just after a rising edge and reads the port at the falling edge of exactly the cycle its due time names. It checks that the cycle before is still quiet, so an early or late write is reported as well as a missing one.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {ST_TIME, ST_ADDR, ST_DATA, ST_WAIT, ST_WRITE} seq_st_t;

  // true when the countdown is on its final tick
  function automatic bit final_tick(input int remaining);
    return remaining == 1;
  endfunction

  // strobes a delay of d ticks spans
  function automatic int strobes_for(input int d, input int ratio);
    return d * ratio;
  endfunction
endpackage

// File: rtl/tw_fifo.sv
module tw_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full, do_push, do_pop, drop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign drop    = push && full && !clear;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
    end else if (clear) begin
      wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (!do_push && do_pop) cnt <= cnt - 1'b1;
      if (drop) ovf <= 1'b1;
    end
  end

  // R1: the parser never pops an empty queue
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R1: occupancy bounded by depth
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  // R7: overflow flag is sticky until clear
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clear) |=> ovf);
endmodule

// File: rtl/tw_tick.sv
module tw_tick #(
  parameter int RATIO = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  input  logic stb,
  output logic tick
);
  localparam int PW = $clog2(RATIO);

  logic [PW-1:0] pre;

  assign tick = enable && stb && !restart && (pre == PW'(RATIO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre <= '0;
    else if (restart)       pre <= '0;
    else if (enable && stb) pre <= tick ? '0 : pre + 1'b1;
  end

  // R8: prescaler holds while disabled
  p_pre_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !restart) |=> $stable(pre));
endmodule

// File: rtl/tw_parser.sv
module tw_parser
  import tw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  input  logic [W-1:0] fifo_dout,
  input  logic         fifo_empty,
  output logic         fifo_pop,
  input  logic         tick,
  output logic         wait_load,
  output logic         wait_active,
  input  logic         host_busy,
  output logic         seq_we,
  output logic [W-1:0] seq_addr,
  output logic [W-1:0] seq_data
);
  seq_st_t      st;
  logic [W-1:0] time_q, cnt;
  logic         fetching;

  assign fetching    = (st == ST_TIME) || (st == ST_ADDR) || (st == ST_DATA);
  assign fifo_pop    = run && fetching && !fifo_empty && !clear;
  assign wait_load   = fifo_pop && (st == ST_DATA) && (time_q != '0);
  assign wait_active = run && (st == ST_WAIT);
  assign seq_we      = run && (st == ST_WRITE) && !host_busy && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_TIME; time_q <= '0; cnt <= '0; seq_addr <= '0; seq_data <= '0;
    end else if (clear) begin
      st <= ST_TIME; cnt <= '0;
    end else begin
      unique case (st)
        ST_TIME: if (fifo_pop) begin time_q <= fifo_dout; st <= ST_ADDR; end
        ST_ADDR: if (fifo_pop) begin seq_addr <= fifo_dout; st <= ST_DATA; end
        ST_DATA: if (fifo_pop) begin
          seq_data <= fifo_dout;
          if (time_q == '0) st <= ST_WRITE;
          else begin cnt <= time_q; st <= ST_WAIT; end
        end
        ST_WAIT: if (tick) begin
          cnt <= cnt - 1'b1;
          if (final_tick(int'(cnt))) st <= ST_WRITE;
        end
        ST_WRITE: if (seq_we) st <= ST_TIME;
        default: st <= ST_TIME;
      endcase
    end
  end

  // R5: a blocked write is retried, not lost
  p_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRITE && run && host_busy && !clear) |=> (st == ST_WRITE));
  // R8: paused parser holds state and count
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> ($stable(st) && $stable(cnt)));
  // R2: after a write the parser expects a new delay byte
  p_next_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we |=> (st == ST_TIME));
endmodule

// File: rtl/tw_seq.sv
module tw_seq #(
  parameter int DEPTH = 512,
  parameter int W     = 8,
  parameter int RATIO = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  input  logic         smp_stb,
  input  logic         fifo_we,
  input  logic [W-1:0] fifo_wdata,
  input  logic         host_we,
  input  logic [W-1:0] host_addr,
  input  logic [W-1:0] host_wdata,
  output logic         reg_we,
  output logic [W-1:0] reg_addr,
  output logic [W-1:0] reg_wdata,
  output logic         fifo_ovf
);
  logic [W-1:0] q_dout, seq_addr, seq_data;
  logic         q_empty, q_pop, tick, wait_load, wait_active, seq_we;

  tw_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(clear), .push(fifo_we), .din(fifo_wdata),
    .pop(q_pop), .dout(q_dout), .empty(q_empty), .ovf(fifo_ovf));

  tw_tick #(.RATIO(RATIO)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(wait_load || clear),
    .enable(wait_active), .stb(smp_stb), .tick(tick));

  tw_parser #(.W(W)) u_parser (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(clear),
    .fifo_dout(q_dout), .fifo_empty(q_empty), .fifo_pop(q_pop),
    .tick(tick), .wait_load(wait_load), .wait_active(wait_active),
    .host_busy(host_we), .seq_we(seq_we), .seq_addr(seq_addr), .seq_data(seq_data));

  assign reg_we    = host_we || seq_we;
  assign reg_addr  = host_we ? host_addr  : seq_addr;
  assign reg_wdata = host_we ? host_wdata : seq_data;

  // R5: the sequencer never drives the port under a host write
  p_host_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> !seq_we);
  // R2: one write per record, never back to back
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we |=> !seq_we);
endmodule

// File: tb/tw_seq_test.sv
`timescale 1ns/1ps
module tw_seq_test;
  localparam int RATIO = 48;
  localparam int NREC  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, clear = 1'b0, smp_stb = 1'b0, fifo_we = 1'b0, host_we = 1'b0;
  logic [7:0] fifo_wdata = '0, host_addr = '0, host_wdata = '0;
  logic reg_we, fifo_ovf;
  logic [7:0] reg_addr, reg_wdata;

  int nchk = 0, nfail = 0, seq_n = 0;
  logic [7:0] log_a [256];
  logic [7:0] log_d [256];
  logic [7:0] ex_a [NREC];
  logic [7:0] ex_d [NREC];

  always #4 clk = ~clk;

  tw_seq uut (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(clear), .smp_stb(smp_stb),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .fifo_ovf(fifo_ovf));

  function automatic int exp_strobes(input int d);
    return d * RATIO;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // port monitor: host writes must pass through, sequencer writes are logged
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (host_we)
        check(reg_addr == host_addr && reg_wdata == host_wdata, "R5 host pass-through",
              {reg_addr, reg_wdata}, {host_addr, host_wdata});
      else begin
        log_a[seq_n[7:0]] = reg_addr;
        log_d[seq_n[7:0]] = reg_wdata;
        seq_n++;
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic push(input logic [7:0] b);
    fifo_we = 1'b1; fifo_wdata = b;
    @(posedge clk); #1;
    fifo_we = 1'b0;
  endtask

  task automatic strobe();
    smp_stb = 1'b1;
    @(posedge clk); #1;
    smp_stb = 1'b0;
    @(posedge clk); #1;
  endtask

  // write due in the second cycle after the last push edge
  task automatic expect_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    check(reg_we == 1'b0, {tag, " early"}, reg_we, 0);
    @(negedge clk);
    check(reg_we && reg_addr == a && reg_wdata == d, tag, {reg_we, reg_addr, reg_wdata},
          {1'b1, a, d});
    @(posedge clk); #1;
  endtask

  // final strobe, write due in the following cycle
  task automatic last_strobe_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    smp_stb = 1'b1;
    @(posedge clk); #1;
    smp_stb = 1'b0;
    @(negedge clk);
    check(reg_we && reg_addr == a && reg_wdata == d, tag, {reg_we, reg_addr, reg_wdata},
          {1'b1, a, d});
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int n0;
    void'($urandom(32'd825));
    cyc(3);
    check(reg_we == 1'b0 && fifo_ovf == 1'b0, "R10 reset state", {reg_we, fifo_ovf}, 0);
    rst_n = 1'b1;
    cyc(2);

    // R4: zero delay
    run = 1'b1;
    push(8'h00); push(8'h21); push(8'h9C);
    expect_write(8'h21, 8'h9C, "R4 zero-delay write");

    // R3: delay of two ticks
    push(8'd2); push(8'h33); push(8'h44);
    cyc(3);
    n0 = seq_n;
    for (int i = 0; i < exp_strobes(2) - 1; i++) strobe();
    check(seq_n == n0, "R3 no write before last strobe", seq_n, n0);
    last_strobe_write(8'h33, 8'h44, "R3 delayed write");

    // R6: stall mid-record
    push(8'h00); push(8'h55);
    n0 = seq_n;
    cyc(20);
    check(seq_n == n0, "R6 stall holds", seq_n, n0);
    push(8'h66);
    expect_write(8'h55, 8'h66, "R6 record completes");

    // R5: host priority and retry
    run = 1'b0;
    push(8'h00); push(8'h77); push(8'h88);
    cyc(3);
    n0 = seq_n;
    host_we = 1'b1; host_addr = 8'hA0; host_wdata = 8'hB1; run = 1'b1;
    cyc(8);
    check(seq_n == n0, "R5 sequencer held off", seq_n, n0);
    host_we = 1'b0;
    @(negedge clk);
    check(reg_we && reg_addr == 8'h77 && reg_wdata == 8'h88, "R5 retry after host",
          {reg_we, reg_addr, reg_wdata}, {1'b1, 8'h77, 8'h88});
    @(posedge clk); #1;

    // R8: pause freezes countdown and prescaler
    push(8'd1); push(8'h12); push(8'h34);
    cyc(3);
    for (int i = 0; i < RATIO - 1; i++) strobe();
    run = 1'b0;
    n0 = seq_n;
    for (int i = 0; i < RATIO; i++) strobe();
    check(seq_n == n0, "R8 no write while paused", seq_n, n0);
    run = 1'b1;
    last_strobe_write(8'h12, 8'h34, "R8 resume after one strobe");

    // R7 and R1: fill, overflow, drain in order
    run = 1'b0;
    for (int i = 0; i < 512; i++) push(8'h00);
    check(fifo_ovf == 1'b0, "R7 no overflow at exactly full", fifo_ovf, 0);
    push(8'hFF);
    check(fifo_ovf == 1'b1, "R7 overflow on full push", fifo_ovf, 1);
    n0 = seq_n;
    run = 1'b1;
    cyc(720);
    check(seq_n == n0 + 170, "R1 full queue drained", seq_n, n0 + 170);
    push(8'h5A);
    expect_write(8'h00, 8'h5A, "R1 dropped byte absent");
    check(fifo_ovf == 1'b1, "R7 flag sticky", fifo_ovf, 1);

    // R9: clear
    push(8'h00); push(8'h11);
    clear = 1'b1; fifo_we = 1'b1; fifo_wdata = 8'h77;
    @(posedge clk); #1;
    clear = 1'b0; fifo_we = 1'b0;
    check(fifo_ovf == 1'b0, "R9 clear lowers flag", fifo_ovf, 0);
    push(8'h00); push(8'hC3); push(8'hD4);
    expect_write(8'hC3, 8'hD4, "R9 fresh record after clear");

    // R2: random records with host traffic and strobes
    n0 = seq_n;
    for (int r = 0; r < NREC; r++) begin
      int d = $urandom % 3;
      ex_a[r] = 8'($urandom);
      ex_d[r] = 8'($urandom);
      push(8'(d));
      if ($urandom % 4 == 0) begin
        host_we = 1'b1; host_addr = 8'($urandom); host_wdata = 8'($urandom);
        cyc(1 + $urandom % 3);
        host_we = 1'b0;
      end
      push(ex_a[r]);
      if ($urandom % 3 == 0) strobe();
      push(ex_d[r]);
      for (int s = 0; s < int'($urandom % 20); s++) strobe();
    end
    for (int s = 0; s < exp_strobes(2) * NREC; s++) strobe();
    cyc(10);
    check(seq_n == n0 + NREC, "R2 one write per record", seq_n, n0 + NREC);
    for (int r = 0; r < NREC; r++)
      check(log_a[(n0 + r) % 256] == ex_a[r] && log_d[(n0 + r) % 256] == ex_d[r],
            "R2 record order", {log_a[(n0 + r) % 256], log_d[(n0 + r) % 256]},
            {ex_a[r], ex_d[r]});

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule